// File: doc/BRIEF.md
# Microprogram Sequencer with Encoded Jump Types

This block steps a micro-program counter through a fixed control store and presents the control word of the current step to a datapath. Each control-store word holds two fields: a control field that drives the datapath, and a 3-bit jump code. The word has no next-address field. A small jump unit works out the following micro-address from three things: the jump code, the current micro-address, and the inputs from the rest of the processor. Those inputs are an opcode, a condition flag and a memory-busy flag.

The control store holds a micro-program that is fixed at build time. The program starts with a three-step instruction fetch. After that come one routine for each supported opcode group, plus a catch-all routine for illegal instructions. A lookup table maps each opcode to the start address of its routine. The datapath is not part of this block. The surrounding logic supplies the opcode, the condition and the busy flag.

Top module: `ucode_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the micro-PC is loaded with 0, the fetch entry. After reset, `upc` reads 0 and `ctrl` reads 18'h00023.
- R2: For jump code 0 (step), the next micro-PC is the current micro-PC plus one.
- R3: For jump code 1 (wait), the micro-PC holds while `busy` is high. When `busy` is low, it advances by one.
- R4: For jump code 2 (restart), the next micro-PC is 0.
- R5: For jump code 3 (branch by opcode), the next micro-PC is the start address for `opcode`. The mapping is: 12 to 3, 4 to 6, 0 to 9, 24 to 14, 27 to 20, 25 to 25. Every other opcode goes to 24.
- R6: For jump code 4 (exit when set), the next micro-PC is 0 when `cond` is high, and the current micro-PC plus one otherwise.
- R7: For jump code 5 (exit when clear), the next micro-PC is 0 when `cond` is low, and the current micro-PC plus one otherwise.
- R8: The fetch routine occupies addresses 0, 1 and 2. Their jump codes are 0, 1 and 3, and their control words are 18'h00023, 18'h00108 and 18'h00090.
- R9: The illegal-instruction step at address 24 sets `trap` (bit 17 of `ctrl`; the whole word is 18'h20000) and has jump code 2. `trap` is low at every other address.
- R10: The routine jump codes are as follows. Address 3 holds 0, 0, 2. Address 6 holds 0, 0, 2. Address 9 holds 0, 0, 0, 1, 2. Address 14 holds 0, 0, 5, 0, 0, 2. Address 20 holds 0, 0, 0, 2. Address 25 holds 4, 2. Every address from 27 to 63 holds code 2.
- R11: `jtype` shows the jump code of the word at the current micro-PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 5 | Opcode group of the current instruction |
| cond | input | 1 | Branch condition from the datapath |
| busy | input | 1 | Memory busy flag |
| upc | output | 6 | Current micro-PC |
| ctrl | output | 18 | Control field of the current word |
| jtype | output | 3 | Jump code of the current word |
| trap | output | 1 | Illegal-instruction flag |

## Verification
The assertions assume that `opcode`, `cond` and `busy` are stable around each rising edge. The bench changes these inputs only on falling edges. The assertions also assume that `busy` eventually falls, so that a wait step can complete. To keep this true, the stimulus raises `busy` only part of the time. The opcode stream runs through every mapped opcode and several unmapped ones, so the branch-by-opcode step reaches each routine, including the illegal one. `cond` is varied so that both exit codes are exercised on both values.

// File: rtl/ucode_pkg.sv
// Package: shared widths, jump codes, control bit positions and key
// micro-addresses for the microprogram sequencer.
package ucode_pkg;
    localparam int UPC_W  = 6;
    localparam int OPC_W  = 5;
    localparam int CTRL_W = 18;
    localparam int JMP_W  = 3;

    typedef enum logic [JMP_W-1:0] {
        JMP_STEP  = 3'd0,
        JMP_WAIT  = 3'd1,
        JMP_FETCH = 3'd2,
        JMP_DISP  = 3'd3,
        JMP_EXITT = 3'd4,
        JMP_EXITF = 3'd5
    } jump_e;

    // Control field bit positions.
    localparam int CB_MA_LD  = 0;
    localparam int CB_A_LD   = 1;
    localparam int CB_B_LD   = 2;
    localparam int CB_IR_LD  = 3;
    localparam int CB_PC_LD  = 4;
    localparam int CB_REG_EN = 5;
    localparam int CB_REG_WR = 6;
    localparam int CB_ALU_EN = 7;
    localparam int CB_MEM_EN = 8;
    localparam int CB_MEM_WR = 9;
    localparam int CB_IMM_EN = 10;
    localparam int CB_TRAP   = CTRL_W - 1;

    // Routine entry points.
    localparam logic [UPC_W-1:0] A_FETCH = 6'd0;
    localparam logic [UPC_W-1:0] A_ALU   = 6'd3;
    localparam logic [UPC_W-1:0] A_ALUI  = 6'd6;
    localparam logic [UPC_W-1:0] A_LOAD  = 6'd9;
    localparam logic [UPC_W-1:0] A_BRAN  = 6'd14;
    localparam logic [UPC_W-1:0] A_JUMP  = 6'd20;
    localparam logic [UPC_W-1:0] A_ILL   = 6'd24;
    localparam logic [UPC_W-1:0] A_SKIP  = 6'd25;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        jump_e             jump;
    } uword_t;
endpackage

// File: rtl/ucode_store.sv
// Control store: a combinational ROM from micro-address to word.
// Assumes: every address outside a routine restarts at fetch with a quiet
// control field.
module ucode_store
    import ucode_pkg::*;
(
    input  logic [UPC_W-1:0] addr,
    output uword_t           word
);
    // Purpose: compose one control field from individual enables.
    function automatic logic [CTRL_W-1:0] cw(input int unsigned b0, input int unsigned b1,
                                             input int unsigned b2);
        logic [CTRL_W-1:0] v;
        v = '0;
        if (b0 < CTRL_W) v[b0] = 1'b1;
        if (b1 < CTRL_W) v[b1] = 1'b1;
        if (b2 < CTRL_W) v[b2] = 1'b1;
        return v;
    endfunction

    localparam int unsigned NONE = 32'hFFFF;

    // Purpose: decode the address into its stored control word and jump code.
    always_comb begin
        word.ctrl = '0;
        word.jump = JMP_FETCH;
        case (addr)
            6'd0:  begin word.ctrl = cw(CB_MA_LD, CB_A_LD, CB_REG_EN);     word.jump = JMP_STEP;  end
            6'd1:  begin word.ctrl = cw(CB_MEM_EN, CB_IR_LD, NONE);        word.jump = JMP_WAIT;  end
            6'd2:  begin word.ctrl = cw(CB_ALU_EN, CB_PC_LD, NONE);        word.jump = JMP_DISP;  end
            // register-register arithmetic
            6'd3:  begin word.ctrl = cw(CB_REG_EN, CB_A_LD, NONE);         word.jump = JMP_STEP;  end
            6'd4:  begin word.ctrl = cw(CB_REG_EN, CB_B_LD, NONE);         word.jump = JMP_STEP;  end
            6'd5:  begin word.ctrl = cw(CB_ALU_EN, CB_REG_WR, CB_REG_EN);  word.jump = JMP_FETCH; end
            // register-immediate arithmetic
            6'd6:  begin word.ctrl = cw(CB_REG_EN, CB_A_LD, NONE);         word.jump = JMP_STEP;  end
            6'd7:  begin word.ctrl = cw(CB_IMM_EN, CB_B_LD, NONE);         word.jump = JMP_STEP;  end
            6'd8:  begin word.ctrl = cw(CB_ALU_EN, CB_REG_WR, CB_REG_EN);  word.jump = JMP_FETCH; end
            // load word
            6'd9:  begin word.ctrl = cw(CB_REG_EN, CB_A_LD, NONE);         word.jump = JMP_STEP;  end
            6'd10: begin word.ctrl = cw(CB_IMM_EN, CB_B_LD, NONE);         word.jump = JMP_STEP;  end
            6'd11: begin word.ctrl = cw(CB_ALU_EN, CB_MA_LD, NONE);        word.jump = JMP_STEP;  end
            6'd12: begin word.ctrl = cw(CB_MEM_EN, NONE, NONE);            word.jump = JMP_WAIT;  end
            6'd13: begin word.ctrl = cw(CB_MEM_EN, CB_REG_WR, CB_REG_EN);  word.jump = JMP_FETCH; end
            // conditional branch
            6'd14: begin word.ctrl = cw(CB_REG_EN, CB_A_LD, NONE);         word.jump = JMP_STEP;  end
            6'd15: begin word.ctrl = cw(CB_REG_EN, CB_B_LD, NONE);         word.jump = JMP_STEP;  end
            6'd16: begin word.ctrl = cw(CB_REG_EN, CB_A_LD, CB_ALU_EN);    word.jump = JMP_EXITF; end
            6'd17: begin word.ctrl = cw(CB_ALU_EN, CB_A_LD, NONE);         word.jump = JMP_STEP;  end
            6'd18: begin word.ctrl = cw(CB_IMM_EN, CB_B_LD, NONE);         word.jump = JMP_STEP;  end
            6'd19: begin word.ctrl = cw(CB_ALU_EN, CB_PC_LD, NONE);        word.jump = JMP_FETCH; end
            // jump and link
            6'd20: begin word.ctrl = cw(CB_REG_WR, CB_REG_EN, NONE);       word.jump = JMP_STEP;  end
            6'd21: begin word.ctrl = cw(CB_ALU_EN, CB_A_LD, NONE);         word.jump = JMP_STEP;  end
            6'd22: begin word.ctrl = cw(CB_IMM_EN, CB_B_LD, NONE);         word.jump = JMP_STEP;  end
            6'd23: begin word.ctrl = cw(CB_ALU_EN, CB_PC_LD, NONE);        word.jump = JMP_FETCH; end
            // illegal instruction
            6'd24: begin word.ctrl = cw(CB_TRAP, NONE, NONE);              word.jump = JMP_FETCH; end
            // conditional skip
            6'd25: begin word.ctrl = cw(CB_ALU_EN, NONE, NONE);            word.jump = JMP_EXITT; end
            6'd26: begin word.ctrl = cw(CB_ALU_EN, CB_PC_LD, NONE);        word.jump = JMP_FETCH; end
            default: begin word.ctrl = '0;                                 word.jump = JMP_FETCH; end
        endcase
    end
endmodule

// File: rtl/ucode_dispatch.sv
// Dispatch table: maps an opcode group to the entry of its routine.
// Assumes: any opcode not listed is illegal and goes to the trap routine.
module ucode_dispatch
    import ucode_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output logic [UPC_W-1:0] entry
);
    // Purpose: look up the routine entry for the opcode.
    always_comb begin
        case (opcode)
            5'd12:   entry = A_ALU;
            5'd4:    entry = A_ALUI;
            5'd0:    entry = A_LOAD;
            5'd24:   entry = A_BRAN;
            5'd27:   entry = A_JUMP;
            5'd25:   entry = A_SKIP;
            default: entry = A_ILL;
        endcase
    end
endmodule

// File: rtl/ucode_next.sv
// Jump unit: computes the next micro-address from the jump code.
// Assumes: codes 6 and 7 are never stored; they restart at fetch.
module ucode_next
    import ucode_pkg::*;
(
    input  jump_e            jump,
    input  logic [UPC_W-1:0] cur,
    input  logic [UPC_W-1:0] entry,
    input  logic             cond,
    input  logic             busy,
    output logic [UPC_W-1:0] nxt
);
    logic [UPC_W-1:0] inc;

    // Purpose: the sequential successor of the current micro-address.
    always_comb inc = cur + UPC_W'(1);

    // Purpose: select the successor according to the jump code.
    always_comb begin
        case (jump)
            JMP_STEP:  nxt = inc;
            JMP_WAIT:  nxt = busy ? cur : inc;
            JMP_FETCH: nxt = A_FETCH;
            JMP_DISP:  nxt = entry;
            JMP_EXITT: nxt = cond ? A_FETCH : inc;
            JMP_EXITF: nxt = cond ? inc : A_FETCH;
            default:   nxt = A_FETCH;
        endcase
    end
endmodule

// File: rtl/ucode_seq.sv
// Top: the micro-PC register plus the store, dispatch and jump units.
// Assumes: opcode, cond and busy are stable around each rising edge.
module ucode_seq
    import ucode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              cond,
    input  logic              busy,
    output logic [UPC_W-1:0]  upc,
    output logic [CTRL_W-1:0] ctrl,
    output logic [JMP_W-1:0]  jtype,
    output logic              trap
);
    uword_t           word;
    logic [UPC_W-1:0] entry;
    logic [UPC_W-1:0] nxt;

    ucode_store    u_store (.addr(upc), .word(word));
    ucode_dispatch u_disp  (.opcode(opcode), .entry(entry));
    ucode_next     u_next  (.jump(word.jump), .cur(upc), .entry(entry),
                            .cond(cond), .busy(busy), .nxt(nxt));

    // Purpose: hold the micro-PC, restarting at fetch on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) upc <= A_FETCH;
        else        upc <= nxt;
    end

    // Purpose: present the current word's fields.
    always_comb begin
        ctrl  = word.ctrl;
        jtype = word.jump;
        trap  = word.ctrl[CB_TRAP];
    end

    a_r2_step_increments: assert property (@(posedge clk) disable iff (!rst_n)
        jtype == JMP_STEP |=> upc == $past(upc) + UPC_W'(1));
    a_r3_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (jtype == JMP_WAIT && busy) |=> $stable(upc));
    a_r3_wait_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (jtype == JMP_WAIT && !busy) |=> upc == $past(upc) + UPC_W'(1));
    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        jtype == JMP_FETCH |=> upc == A_FETCH);
    a_r5_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
        jtype == JMP_DISP |=> upc == $past(entry));
    a_r6_exit_set: assert property (@(posedge clk) disable iff (!rst_n)
        (jtype == JMP_EXITT && cond) |=> upc == A_FETCH);
    a_r7_exit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (jtype == JMP_EXITF && !cond) |=> upc == A_FETCH);
    a_r9_trap_only_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> upc == A_ILL);
endmodule

// File: tb/test_ucode_seq.sv
// Bench: behavioural micro-program model compared on every clock.
module test_ucode_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NCYC = 4000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] opcode = 5'd0;
    logic       cond = 1'b0;
    logic       busy = 1'b0;
    logic [5:0] upc;
    logic [17:0] ctrl;
    logic [2:0] jtype;
    logic       trap;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int exp_upc = 0;

    ucode_seq i_ucode_seq (.clk(clk), .rst_n(rst_n), .opcode(opcode), .cond(cond),
                           .busy(busy), .upc(upc), .ctrl(ctrl), .jtype(jtype), .trap(trap));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Jump code per address, from the routine layout of R8, R9 and R10.
    function automatic int code_at(int a);
        if (a == 0) return 0;
        if (a == 1) return 1;
        if (a == 2) return 3;
        if (a == 5 || a == 8 || a == 13 || a == 19 || a == 23 || a == 24 || a == 26) return 2;
        if (a == 12) return 1;
        if (a == 16) return 5;
        if (a == 25) return 4;
        if (a >= 3 && a <= 23) return 0;
        return 2;
    endfunction

    // Opcode to entry, per R5.
    function automatic int entry_of(int op);
        case (op)
            12: return 3;
            4:  return 6;
            0:  return 9;
            24: return 14;
            27: return 20;
            25: return 25;
            default: return 24;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int ops[10] = '{12, 4, 0, 24, 27, 25, 3, 31, 17, 8};
        int nxt;
        string tag;
        tag = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset upc", upc, 0);
        check("R1 reset ctrl", ctrl, 'h23);
        rst_n = 1'b1;
        exp_upc = 0;
        for (int i = 0; i < NCYC; i++) begin
            // Compare outputs against the model.
            check({tag, " upc"}, upc, exp_upc);
            check("R11/R10 jtype", jtype, code_at(exp_upc));
            check("R9 trap", trap, (exp_upc == 24) ? 1 : 0);
            if (exp_upc == 0) check("R8 fetch0 ctrl", ctrl, 'h23);
            if (exp_upc == 1) check("R8 fetch1 ctrl", ctrl, 'h108);
            if (exp_upc == 2) check("R8 fetch2 ctrl", ctrl, 'h90);
            if (exp_upc == 24) check("R9 illegal ctrl", ctrl, 'h20000);
            // Drive fresh inputs.
            opcode = 5'(ops[(i / 7) % 10]);
            cond   = 1'($urandom_range(0, 1));
            busy   = ($urandom_range(0, 2) == 0);
            // Model the next micro-address.
            case (code_at(exp_upc))
                0: begin nxt = exp_upc + 1; tag = "R2"; end
                1: begin nxt = busy ? exp_upc : exp_upc + 1; tag = "R3"; end
                2: begin nxt = 0; tag = "R4"; end
                3: begin nxt = entry_of(int'(opcode)); tag = "R5"; end
                4: begin nxt = cond ? 0 : exp_upc + 1; tag = "R6"; end
                default: begin nxt = cond ? exp_upc + 1 : 0; tag = "R7"; end
            endcase
            @(negedge clk);
            exp_upc = nxt;
        end
        // Reset taken from a non-fetch address.
        while (upc == 0) begin
            busy = 1'b0;
            @(negedge clk);
        end
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset upc", upc, 0);
        check("R1 mid-run reset ctrl", ctrl, 'h23);
        finish_run();
    end
endmodule